// File: doc/BRIEF.md
# Thread Interrupt Priority Presenter

This block keeps the interrupt management state of one hardware thread for four privilege rings: physical (ring 0), hypervisor (ring 1), operating system (ring 2) and user (ring 3). Each ring has an 8-bit pending buffer with one bit per priority, a current-priority register, and a derived pending-priority value. The pending-priority value is the most favoured priority that is pending. There are eight priority levels, and a lower number is more favoured. A ring raises its interrupt line when its pending priority is numerically below its current priority.

Notifications arrive on a dedicated input as a ring and a priority. Software reaches the contexts through a single-cycle register port whose address space is split into four aligned pages. Each page gives one ring its own view. The ring-0 page can reach all four contexts. An acknowledge is a read of a dedicated offset. It returns the notification source and pending priority, and it takes the pending interrupt: it retires the pending bit and moves the current priority up to the acknowledged level.

Top module: `tipp_top`

## Requirements
- R1: After reset, every ring has current priority 0xFF, pending priority 0xFF and pending buffer 0, and `irq` is 0.
- R2: A notification with `ntf_valid` high, ring r and priority p sets bit p of ring r's pending buffer, which is read at register index 2. The pending buffers of the other rings are not changed.
- R3: The pending priority, read at register index 3, equals the index of the lowest set bit of the pending buffer, or 0xFF when the buffer is empty.
- R4: `irq[r]` and bit 7 of ring r's notification source register (register index 0, other bits zero) are high exactly when the pending priority is less than the current priority, compared as unsigned 8-bit values. Equal values do not raise them.
- R5: A write to register index 1 loads the current priority, and `irq` reflects the new value in the cycle after the write edge.
- R6: A read of register index 4 returns the notification source register in bits 15:8 and the pending priority in bits 7:0. If the exception bit is set, the clock edge clears the pending bit at that priority, loads the current priority with that priority, and drops the interrupt line.
- R7: An acknowledge while the exception bit is clear returns 0x00FF when nothing is pending and changes no state.
- R8: `reg_addr[6:5]` selects the page, and page k is the view of ring k. In page 0, `reg_addr[4:3]` selects the target ring. In every page, `reg_addr[2:0]` is the register index.
- R9: An access in page 1, 2 or 3 with a nonzero `reg_addr[4:3]`, or an access to register index 5, 6 or 7, reads as zero and its writes have no effect.
- R10: Writes to the notification source, pending buffer and pending priority registers are ignored.
- R11: A notification and an acknowledge to the same ring in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ntf_valid | input | 1 | Notification strobe |
| ntf_ring | input | 2 | Target ring of the notification |
| ntf_prio | input | 3 | Priority of the notification |
| reg_addr | input | 7 | Page, ring select and register index |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write enable |
| reg_re | input | 1 | Read enable; needed only for the acknowledge side effect |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| irq | output | 4 | Interrupt line of each ring |

## Verification
The assertions assume that `reg_we` and `reg_re` are never high in the same cycle. They also assume that an acknowledge is sampled only after reset has been released. The bench drives exactly one register operation per cycle, and it changes inputs only at the falling edge. The assertion on current-priority writes allows for a concurrent acknowledge of the same ring. The bench never issues both at once, so that rule is checked only in its plain form.

// File: rtl/tipp_pkg.sv
package tipp_pkg;
   localparam int PRIO_REG_W = 8;
   localparam logic [PRIO_REG_W-1:0] PRIO_NONE = 8'hFF;
   localparam int EX_BIT = 7;

   typedef enum logic [2:0] {
      RIX_NSR  = 3'd0,
      RIX_CPPR = 3'd1,
      RIX_IPB  = 3'd2,
      RIX_PIPR = 3'd3,
      RIX_ACK  = 3'd4
   } reg_ix_e;
endpackage

// File: rtl/tipp_prio_enc.sv
module tipp_prio_enc
   import tipp_pkg::*;
#(
   parameter int NUM_PRIO = 8,
   parameter bit SPLIT    = 1'b1
) (
   input  logic [NUM_PRIO-1:0]   pend,
   output logic [PRIO_REG_W-1:0] best
);
   localparam int HALF = NUM_PRIO / 2;

   if (NUM_PRIO < 2 || NUM_PRIO > 255) begin : g_bad_n
      $error("tipp_prio_enc: NUM_PRIO out of range");
   end

   if (SPLIT && (NUM_PRIO % 2 == 0)) begin : g_split
      logic [PRIO_REG_W-1:0] lo_ix, hi_ix;
      logic                  lo_any, hi_any;
      always_comb begin
         lo_ix  = '0;
         lo_any = 1'b0;
         for (int i = HALF - 1; i >= 0; i--) begin
            if (pend[i]) begin
               lo_ix  = PRIO_REG_W'(i);
               lo_any = 1'b1;
            end
         end
         hi_ix  = '0;
         hi_any = 1'b0;
         for (int i = NUM_PRIO - 1; i >= HALF; i--) begin
            if (pend[i]) begin
               hi_ix  = PRIO_REG_W'(i);
               hi_any = 1'b1;
            end
         end
         if (lo_any)      best = lo_ix;
         else if (hi_any) best = hi_ix;
         else             best = PRIO_NONE;
      end
   end else begin : g_linear
      always_comb begin
         best = PRIO_NONE;
         for (int i = NUM_PRIO - 1; i >= 0; i--) begin
            if (pend[i]) best = PRIO_REG_W'(i);
         end
      end
   end
endmodule

// File: rtl/tipp_ring_ctx.sv
module tipp_ring_ctx
   import tipp_pkg::*;
#(
   parameter int NUM_PRIO  = 8,
   parameter bit ENC_SPLIT = 1'b1,
   localparam int PW = $clog2(NUM_PRIO)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ntf_hit,
   input  logic [PW-1:0]         ntf_prio,
   input  logic                  cppr_we,
   input  logic [PRIO_REG_W-1:0] cppr_wdata,
   input  logic                  ack_req,
   output logic [NUM_PRIO-1:0]   ipb,
   output logic [PRIO_REG_W-1:0] pipr,
   output logic [PRIO_REG_W-1:0] cppr,
   output logic                  ex
);
   logic [NUM_PRIO-1:0]   set_mask, clr_mask, ipb_d;
   logic [PRIO_REG_W-1:0] cppr_d;
   logic                  ack_take;

   tipp_prio_enc #(.NUM_PRIO(NUM_PRIO), .SPLIT(ENC_SPLIT)) u_enc (
      .pend (ipb),
      .best (pipr)
   );

   assign ex       = (pipr < cppr);
   assign ack_take = ack_req && ex;

   always_comb begin
      set_mask = '0;
      clr_mask = '0;
      if (ntf_hit)  set_mask = NUM_PRIO'(1) << ntf_prio;
      if (ack_take) clr_mask = NUM_PRIO'(1) << pipr[PW-1:0];
      ipb_d = (ipb & ~clr_mask) | set_mask;
      if (ack_take)     cppr_d = pipr;
      else if (cppr_we) cppr_d = cppr_wdata;
      else              cppr_d = cppr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ipb  <= '0;
         cppr <= PRIO_NONE;
      end else begin
         ipb  <= ipb_d;
         cppr <= cppr_d;
      end
   end

   AST_NTF_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      ntf_hit |=> ipb[$past(ntf_prio)]); // R2
   AST_PIPR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (ipb == '0) |-> (pipr == PRIO_NONE)); // R3
   AST_PIPR_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (pipr != PRIO_NONE) |-> ipb[pipr[PW-1:0]]); // R3
   AST_EX_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      ex |-> (ipb != '0)); // R4
   AST_CPPR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cppr_we && !ack_req) |=> (cppr == $past(cppr_wdata))); // R5
   AST_ACK_CPPR: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && ex) |=> (cppr == $past(pipr))); // R6
   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && ex && !ntf_hit && !cppr_we) |=> !ex); // R6
   AST_IDLE_ACK_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && !ex && !ntf_hit && !cppr_we) |=> ($stable(ipb) && $stable(cppr))); // R7
endmodule

// File: rtl/tipp_top.sv
module tipp_top
   import tipp_pkg::*;
#(
   parameter int NUM_PRIO  = 8,
   parameter int NUM_RINGS = 4,
   parameter int REG_IX_W  = 3,
   parameter int DATA_W    = 16,
   parameter bit ENC_SPLIT = 1'b1,
   localparam int PW       = $clog2(NUM_PRIO),
   localparam int RW       = $clog2(NUM_RINGS),
   localparam int ADDR_W   = 2 * RW + REG_IX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ntf_valid,
   input  logic [RW-1:0]     ntf_ring,
   input  logic [PW-1:0]     ntf_prio,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_we,
   input  logic              reg_re,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [NUM_RINGS-1:0] irq
);
   localparam int SUB_LSB  = REG_IX_W;
   localparam int PAGE_LSB = REG_IX_W + RW;

   if (NUM_RINGS != 4) begin : g_bad_rings
      $error("tipp_top: the page map needs exactly four rings");
   end
   if (NUM_PRIO > 8) begin : g_bad_prio
      $error("tipp_top: NUM_PRIO must fit an 8-bit pending buffer");
   end
   if (DATA_W < 2 * PRIO_REG_W) begin : g_bad_data
      $error("tipp_top: DATA_W too narrow for acknowledge data");
   end
   if (REG_IX_W < 3) begin : g_bad_ix
      $error("tipp_top: REG_IX_W must hold index 4");
   end

   logic [RW-1:0]       page, sub, tgt;
   logic [REG_IX_W-1:0] rix;
   logic                acc_ok;

   logic [NUM_RINGS-1:0][NUM_PRIO-1:0]   ipb_all;
   logic [NUM_RINGS-1:0][PRIO_REG_W-1:0] pipr_all, cppr_all;
   logic [NUM_RINGS-1:0]                 ex_all;

   assign page   = reg_addr[PAGE_LSB +: RW];
   assign sub    = reg_addr[SUB_LSB +: RW];
   assign rix    = reg_addr[REG_IX_W-1:0];
   assign acc_ok = (page == '0) || (sub == '0);
   assign tgt    = (page == '0) ? sub : page;

   for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
      logic hit_r, wr_r, ack_r;
      assign hit_r = ntf_valid && (ntf_ring == RW'(r));
      assign wr_r  = reg_we && acc_ok && (tgt == RW'(r)) &&
                     (rix == REG_IX_W'(RIX_CPPR));
      assign ack_r = reg_re && acc_ok && (tgt == RW'(r)) &&
                     (rix == REG_IX_W'(RIX_ACK));

      tipp_ring_ctx #(.NUM_PRIO(NUM_PRIO), .ENC_SPLIT(ENC_SPLIT)) u_ctx (
         .clk        (clk),
         .rst_n      (rst_n),
         .ntf_hit    (hit_r),
         .ntf_prio   (ntf_prio),
         .cppr_we    (wr_r),
         .cppr_wdata (reg_wdata),
         .ack_req    (ack_r),
         .ipb        (ipb_all[r]),
         .pipr       (pipr_all[r]),
         .cppr       (cppr_all[r]),
         .ex         (ex_all[r])
      );
      assign irq[r] = ex_all[r];
   end

   logic [PRIO_REG_W-1:0] nsr_sel;
   assign nsr_sel = {ex_all[tgt], 7'b0};

   always_comb begin
      reg_rdata = '0;
      if (acc_ok) begin
         case (rix)
            REG_IX_W'(RIX_NSR):  reg_rdata = DATA_W'(nsr_sel);
            REG_IX_W'(RIX_CPPR): reg_rdata = DATA_W'(cppr_all[tgt]);
            REG_IX_W'(RIX_IPB):  reg_rdata = DATA_W'(ipb_all[tgt]);
            REG_IX_W'(RIX_PIPR): reg_rdata = DATA_W'(pipr_all[tgt]);
            REG_IX_W'(RIX_ACK):  reg_rdata = DATA_W'({nsr_sel, pipr_all[tgt]});
            default:             reg_rdata = '0;
         endcase
      end
   end

   AST_BAD_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !acc_ok && !reg_re) |=> $stable(cppr_all)); // R9
   AST_NO_WR_RD_MIX: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_re)); // R8
endmodule

// File: tb/tipp_top_tb_top.sv
module tipp_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ntf_valid = 1'b0;
   logic [1:0]  ntf_ring = '0;
   logic [2:0]  ntf_prio = '0;
   logic [6:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic        reg_we = 1'b0;
   logic        reg_re = 1'b0;
   logic [15:0] reg_rdata;
   logic [3:0]  irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tipp_top dut_i (
      .clk(clk), .rst_n(rst_n), .ntf_valid(ntf_valid), .ntf_ring(ntf_ring),
      .ntf_prio(ntf_prio), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .irq(irq)
   );

   typedef struct packed {
      logic [1:0]  op;     // 0 notify, 1 write, 2 read
      logic [1:0]  nring;
      logic [2:0]  nprio;
      logic [6:0]  addr;   // {page, sub, index}
      logic [7:0]  wd;
      logic [15:0] erd;
      logic [3:0]  eirq;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 2'd2, 3'd5, 7'd0,               8'h00, 16'h0000, 4'b0100, 4'd2}, // R2
      '{2'd2, 2'd0, 3'd0, {2'd2,2'd0,3'd2},   8'h00, 16'h0020, 4'b0100, 4'd2}, // R2
      '{2'd2, 2'd0, 3'd0, {2'd2,2'd0,3'd3},   8'h00, 16'h0005, 4'b0100, 4'd3}, // R3
      '{2'd1, 2'd0, 3'd0, {2'd2,2'd0,3'd1},   8'h03, 16'h0000, 4'b0000, 4'd5}, // R5
      '{2'd2, 2'd0, 3'd0, {2'd2,2'd0,3'd0},   8'h00, 16'h0000, 4'b0000, 4'd4}, // R4
      '{2'd0, 2'd2, 3'd1, 7'd0,               8'h00, 16'h0000, 4'b0100, 4'd4}, // R4
      '{2'd2, 2'd0, 3'd0, {2'd2,2'd0,3'd3},   8'h00, 16'h0001, 4'b0100, 4'd3}, // R3
      '{2'd2, 2'd0, 3'd0, {2'd2,2'd0,3'd4},   8'h00, 16'h8001, 4'b0000, 4'd6}, // R6
      '{2'd2, 2'd0, 3'd0, {2'd2,2'd0,3'd1},   8'h00, 16'h0001, 4'b0000, 4'd6}, // R6
      '{2'd2, 2'd0, 3'd0, {2'd2,2'd0,3'd2},   8'h00, 16'h0020, 4'b0000, 4'd6}, // R6
      '{2'd1, 2'd0, 3'd0, {2'd2,2'd0,3'd1},   8'h07, 16'h0000, 4'b0100, 4'd5}, // R5
      '{2'd0, 2'd0, 3'd0, 7'd0,               8'h00, 16'h0000, 4'b0101, 4'd2}, // R2
      '{2'd2, 2'd0, 3'd0, {2'd0,2'd2,3'd3},   8'h00, 16'h0005, 4'b0101, 4'd8}, // R8
      '{2'd2, 2'd0, 3'd0, {2'd0,2'd0,3'd0},   8'h00, 16'h0080, 4'b0101, 4'd8}, // R8
      '{2'd2, 2'd0, 3'd0, {2'd1,2'd1,3'd3},   8'h00, 16'h0000, 4'b0101, 4'd9}, // R9
      '{2'd2, 2'd0, 3'd0, {2'd0,2'd0,3'd5},   8'h00, 16'h0000, 4'b0101, 4'd9}  // R9
   };

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic nv, input logic [1:0] nr, input logic [2:0] np,
                       input logic we, input logic re, input logic [6:0] a,
                       input logic [7:0] d, output logic [15:0] rd);
      @(negedge clk);
      ntf_valid = nv; ntf_ring = nr; ntf_prio = np;
      reg_we = we; reg_re = re; reg_addr = a; reg_wdata = d;
      #2 rd = reg_rdata;
      @(posedge clk);
      #1;
      ntf_valid = 1'b0; reg_we = 1'b0; reg_re = 1'b0;
   endtask

   task automatic rd_reg(input logic [6:0] a, output logic [15:0] rd);
      step(1'b0, 2'd0, 3'd0, 1'b0, 1'b1, a, 8'h00, rd);
   endtask

   task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
      logic [15:0] rd;
      step(1'b0, 2'd0, 3'd0, 1'b1, 1'b0, a, d, rd);
   endtask

   task automatic notify(input logic [1:0] r, input logic [2:0] p);
      logic [15:0] rd;
      step(1'b1, r, p, 1'b0, 1'b0, 7'd0, 8'h00, rd);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] rd;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state of every context, reached through the ring-0 page
      chk("R1", "irq", {12'h0, irq}, 16'h0000);
      for (int s = 0; s < 4; s++) begin
         rd_reg({2'd0, 2'(s), 3'd1}, rd); chk("R1", "cppr", rd, 16'h00FF);
         rd_reg({2'd0, 2'(s), 3'd3}, rd); chk("R1", "pipr", rd, 16'h00FF);
         rd_reg({2'd0, 2'(s), 3'd2}, rd); chk("R1", "ipb", rd, 16'h0000);
      end

      for (int i = 0; i < NV; i++) begin
         case (VECS[i].op)
            2'd0: notify(VECS[i].nring, VECS[i].nprio);
            2'd1: wr_reg(VECS[i].addr, VECS[i].wd);
            default: begin
               rd_reg(VECS[i].addr, rd);
               chk($sformatf("R%0d", VECS[i].req), $sformatf("row %0d rdata", i),
                   rd, VECS[i].erd);
            end
         endcase
         chk($sformatf("R%0d", VECS[i].req), $sformatf("row %0d irq", i),
             {12'h0, irq}, {12'h0, VECS[i].eirq});
      end

      // R7: acknowledge on an idle ring
      rd_reg({2'd3, 2'd0, 3'd4}, rd); chk("R7", "idle ack data", rd, 16'h00FF);
      chk("R7", "irq after idle ack", {12'h0, irq}, 16'h0005);
      rd_reg({2'd3, 2'd0, 3'd1}, rd); chk("R7", "cppr kept", rd, 16'h00FF);
      rd_reg({2'd3, 2'd0, 3'd2}, rd); chk("R7", "ipb kept", rd, 16'h0000);

      // R10: read-only registers ignore writes
      wr_reg({2'd2, 2'd0, 3'd2}, 8'hFF);
      rd_reg({2'd2, 2'd0, 3'd2}, rd); chk("R10", "ipb unchanged", rd, 16'h0020);
      wr_reg({2'd2, 2'd0, 3'd3}, 8'h00);
      rd_reg({2'd2, 2'd0, 3'd3}, rd); chk("R10", "pipr unchanged", rd, 16'h0005);
      wr_reg({2'd2, 2'd0, 3'd0}, 8'h00);
      rd_reg({2'd2, 2'd0, 3'd0}, rd); chk("R10", "nsr unchanged", rd, 16'h0080);

      // R9: writes through unimplemented offsets have no effect
      wr_reg({2'd1, 2'd2, 3'd1}, 8'h00);
      rd_reg({2'd2, 2'd0, 3'd1}, rd); chk("R9", "ring2 cppr", rd, 16'h0007);
      rd_reg({2'd1, 2'd0, 3'd1}, rd); chk("R9", "ring1 cppr", rd, 16'h00FF);
      wr_reg({2'd0, 2'd0, 3'd6}, 8'h00);
      chk("R9", "irq after bad write", {12'h0, irq}, 16'h0005);

      // R11: notification and acknowledge in the same cycle
      notify(2'd1, 3'd4);
      chk("R11", "irq ring1 raised", {12'h0, irq}, 16'h0007);
      step(1'b1, 2'd1, 3'd2, 1'b0, 1'b1, {2'd1, 2'd0, 3'd4}, 8'h00, rd);
      chk("R11", "ack data", rd, 16'h8004);
      chk("R11", "irq after", {12'h0, irq}, 16'h0007);
      rd_reg({2'd1, 2'd0, 3'd2}, rd); chk("R11", "ipb", rd, 16'h0004);
      rd_reg({2'd1, 2'd0, 3'd1}, rd); chk("R11", "cppr", rd, 16'h0004);
      rd_reg({2'd1, 2'd0, 3'd3}, rd); chk("R11", "pipr", rd, 16'h0002);

      // R4: equal priorities do not interrupt
      notify(2'd3, 3'd6);
      chk("R4", "ring3 raised", {12'h0, irq}, 16'h000F);
      wr_reg({2'd3, 2'd0, 3'd1}, 8'h06);
      chk("R4", "equal masks", {12'h0, irq}, 16'h0007);
      rd_reg({2'd3, 2'd0, 3'd0}, rd); chk("R4", "nsr clear", rd, 16'h0000);
      wr_reg({2'd3, 2'd0, 3'd1}, 8'h07);
      chk("R4", "below raises", {12'h0, irq}, 16'h000F);

      // R5: most favoured current priority blocks ring 0
      wr_reg({2'd0, 2'd0, 3'd1}, 8'h00);
      chk("R5", "ring0 blocked", {12'h0, irq}, 16'h000E);

      finish_run();
   end
endmodule